// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block places a small two-way set-associative data cache between a processor that issues byte reads and writes and a slower main memory that moves whole lines. A byte address is cut into a tag, a set index and a byte offset. Each set holds two lines, and each line has a valid flag, a dirty flag and a stored tag. One recency bit per set picks the way to replace. A read miss brings the whole line in before the byte is returned.

Two mode inputs choose how the cache behaves at run time. One input turns caching off, so every access goes straight to memory. The other input chooses write-through, where every write is forwarded to memory, or write-back, where writes stay in the cache until the line is evicted. Two maintenance commands walk every line of every set. One drops all contents. The other first copies dirty lines back to memory and then drops everything.

The default parameters give a 24-bit address, 4-byte lines and 64 sets. Setting `SET_W` to 13 gives a 9-bit tag, a 13-bit set index and a 2-bit offset, which is 8192 sets. The mode inputs must stay stable while an access or a command is in progress.

Top module: `cache_wb2way`

## Requirements
- R1: After reset, `cpu_ready`, `cmd_done` and `mem_req` are low and every line is invalid, so the first access to any set is a miss.
- R2: A lookup compares the address tag with both ways of the indexed set. A match on a valid way is a hit. A read hit returns the byte at `cpu_addr[OFF_W-1:0]` without any memory transfer.
- R3: A read miss issues exactly one line read at line address `cpu_addr[ADDR_W-1:OFF_W]`. It returns byte k of the line, at bits `[8k+7:8k]`, where k is the byte offset.
- R4: On a miss, an invalid way is filled first, way 0 before way 1. When both ways are valid, the way not most recently used is replaced. Every hit and every fill marks its way as most recently used.
- R5: In write-back mode (`cfg_wthru`=0), a write hit changes only the cached line and marks it dirty, with no memory transfer. A write miss fetches the line and then merges the byte into it.
- R6: A dirty victim is written back as a full line (`mem_be`=all ones) before the fill read for the same miss. A clean victim is overwritten with no memory write.
- R7: In write-through mode (`cfg_wthru`=1), every write sends one byte write to memory with `mem_be` one-hot at the byte offset. A write hit also updates the cached copy. A write miss does not allocate a line. No line becomes dirty in this mode.
- R8: With `cfg_disable`=1, every read is a line read from memory and every write is a one-byte memory write. Tags, valid, dirty and recency state are not touched.
- R9: `cmd_clean` writes every dirty line back to memory, invalidates all lines and then raises `cmd_done` for one cycle.
- R10: `cmd_inval` invalidates all lines without any memory transfer, so dirty data is discarded.
- R11: `mem_req` stays high with stable address, direction and data until `mem_ack`. `cpu_ready` and `cmd_done` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_disable | input | 1 | Bypass the cache: all accesses go to memory |
| cfg_wthru | input | 1 | 1 = write-through, 0 = write-back |
| cmd_inval | input | 1 | Invalidate-all command, held until `cmd_done` |
| cmd_clean | input | 1 | Write back dirty lines, then invalidate; held until `cmd_done` |
| cmd_done | output | 1 | One-cycle pulse when a command finishes |
| cpu_req | input | 1 | Processor access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = byte write, 0 = byte read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 8 | Write byte |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 8 | Read byte, valid while `cpu_ready` is high |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | 1 = write, 0 = line read |
| mem_addr | output | ADDR_W-OFF_W | Line address |
| mem_be | output | 2**OFF_W | Byte enables for a write |
| mem_wdata | output | 8*2**OFF_W | Write line |
| mem_ack | input | 1 | Memory completion; read data valid in the same cycle |
| mem_rdata | input | 8*2**OFF_W | Read line |

## Verification
The bench targets replacement order inside a full set. A design with an inverted recency bit would evict the line it had just used, and this shows up as an extra line read on a later access that should have hit. It checks that a dirty victim reaches memory before the fill and that a clean victim causes no write. A design that dropped the dirty flag would lose data, and one that always wrote back would show spurious write traffic. It also checks that write-through misses do not allocate and never leave dirty lines that a later clean command would flush, that bypass mode leaves no residue in the tag state, and that a plain invalidate really discards dirty bytes instead of writing them back.

// File: rtl/cache_pkg.sv
package cache_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_MEM,
      ST_EVICT,
      ST_FILL,
      ST_RESP,
      ST_SCAN,
      ST_FLWB,
      ST_FDONE
   } cstate_t;
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
   parameter int SET_W = 6,
   parameter int TAG_W = 16,
   localparam int SETS = 1 << SET_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_disable,
   input  logic                  cfg_wthru,
   input  logic [SET_W-1:0]      rd_set,
   output logic [1:0]            rd_valid,
   output logic [1:0]            rd_dirty,
   output logic [1:0][TAG_W-1:0] rd_tag,
   output logic                  rd_lru,
   input  logic                  wr_en,
   input  logic                  wr_way,
   input  logic [TAG_W-1:0]      wr_tag,
   input  logic                  wr_dirty,
   input  logic                  lru_en,
   input  logic                  lru_val,
   input  logic                  clr_en,
   input  logic                  clr_way
);
   logic [SETS-1:0] lru_a;

   for (genvar w = 0; w < 2; w++) begin : g_way
      logic [TAG_W-1:0] tag_a [SETS];
      logic [SETS-1:0]  vld_a;
      logic [SETS-1:0]  drt_a;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_a <= '0;
            drt_a <= '0;
         end else if (wr_en && wr_way == 1'(w)) begin
            vld_a[rd_set] <= 1'b1;
            drt_a[rd_set] <= wr_dirty;
         end else if (clr_en && clr_way == 1'(w)) begin
            vld_a[rd_set] <= 1'b0;
            drt_a[rd_set] <= 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (wr_en && wr_way == 1'(w)) tag_a[rd_set] <= wr_tag;
      end

      assign rd_valid[w] = vld_a[rd_set];
      assign rd_dirty[w] = drt_a[rd_set];
      assign rd_tag[w]   = tag_a[rd_set];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lru_a <= '0;
      else if (lru_en)  lru_a[rd_set] <= lru_val;
      else if (clr_en)  lru_a[rd_set] <= 1'b0;
   end

   assign rd_lru = lru_a[rd_set];

   // R7
   wthru_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_dirty) |-> !cfg_wthru);

   // R8
   nocache_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en || lru_en) |-> !cfg_disable);
endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
   parameter int SET_W  = 6,
   parameter int LINE_W = 32,
   localparam int SETS  = 1 << SET_W
) (
   input  logic                   clk,
   input  logic [SET_W-1:0]       rd_set,
   output logic [1:0][LINE_W-1:0] rd_line,
   input  logic                   wr_en,
   input  logic                   wr_way,
   input  logic [LINE_W-1:0]      wr_line
);
   for (genvar w = 0; w < 2; w++) begin : g_way
      logic [LINE_W-1:0] line_a [SETS];

      always_ff @(posedge clk) begin
         if (wr_en && wr_way == 1'(w)) line_a[rd_set] <= wr_line;
      end

      assign rd_line[w] = line_a[rd_set];
   end
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
   import cache_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int SET_W  = 6,
   parameter int OFF_W  = 2,
   localparam int TAG_W   = ADDR_W - SET_W - OFF_W,
   localparam int BYTES   = 1 << OFF_W,
   localparam int LINE_W  = 8 * BYTES,
   localparam int LADDR_W = ADDR_W - OFF_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_disable,
   input  logic                   cfg_wthru,
   input  logic                   cmd_inval,
   input  logic                   cmd_clean,
   output logic                   cmd_done,
   input  logic                   cpu_req,
   input  logic                   cpu_we,
   input  logic [ADDR_W-1:0]      cpu_addr,
   input  logic [7:0]             cpu_wdata,
   output logic                   cpu_ready,
   output logic [7:0]             cpu_rdata,
   output logic                   mem_req,
   output logic                   mem_we,
   output logic [LADDR_W-1:0]     mem_addr,
   output logic [BYTES-1:0]       mem_be,
   output logic [LINE_W-1:0]      mem_wdata,
   input  logic                   mem_ack,
   input  logic [LINE_W-1:0]      mem_rdata,
   output logic [SET_W-1:0]       ts_set,
   input  logic [1:0]             ts_valid,
   input  logic [1:0]             ts_dirty,
   input  logic [1:0][TAG_W-1:0]  ts_tag,
   input  logic                   ts_lru,
   output logic                   ts_wr_en,
   output logic                   ts_wr_way,
   output logic [TAG_W-1:0]       ts_wr_tag,
   output logic                   ts_wr_dirty,
   output logic                   ts_lru_en,
   output logic                   ts_lru_val,
   output logic                   ts_clr_en,
   output logic                   ts_clr_way,
   input  logic [1:0][LINE_W-1:0] ds_line,
   output logic                   ds_wr_en,
   output logic                   ds_wr_way,
   output logic [LINE_W-1:0]      ds_wr_line
);
   cstate_t           st;
   logic [ADDR_W-1:0] addr_q;
   logic              we_q;
   logic [7:0]        wdata_q;
   logic [7:0]        rdata_q;
   logic              way_q;
   logic [SET_W-1:0]  fl_set;
   logic              fl_way;
   logic              fl_clean;

   logic [ADDR_W-1:0] cur_addr;
   logic [SET_W-1:0]  cur_set;
   logic [TAG_W-1:0]  cur_tag;
   logic [OFF_W-1:0]  cur_off;
   logic [1:0]        hit_v;
   logic              hit, hit_way, victim;
   logic              scan_wb, fl_last, adv, cmd_any;

   function automatic logic [LINE_W-1:0] merge_byte(input logic [LINE_W-1:0] l,
                                                    input logic [OFF_W-1:0]  o,
                                                    input logic [7:0]        b);
      logic [LINE_W-1:0] r;
      r = l;
      r[o*8 +: 8] = b;
      return r;
   endfunction

   function automatic logic [7:0] pick_byte(input logic [LINE_W-1:0] l,
                                            input logic [OFF_W-1:0]  o);
      return l[o*8 +: 8];
   endfunction

   assign cur_addr = (st == ST_IDLE) ? cpu_addr : addr_q;
   assign cur_set  = cur_addr[OFF_W +: SET_W];
   assign cur_tag  = cur_addr[ADDR_W-1 -: TAG_W];
   assign cur_off  = cur_addr[OFF_W-1:0];
   assign ts_set   = (st == ST_SCAN || st == ST_FLWB) ? fl_set : cur_set;

   for (genvar w = 0; w < 2; w++) begin : g_cmp
      assign hit_v[w] = ts_valid[w] && (ts_tag[w] == cur_tag);
   end
   assign hit     = |hit_v;
   assign hit_way = hit_v[1];
   assign victim  = !ts_valid[0] ? 1'b0 : (!ts_valid[1] ? 1'b1 : ts_lru);
   assign scan_wb = fl_clean && ts_valid[fl_way] && ts_dirty[fl_way];
   assign fl_last = (&fl_set) && fl_way;
   assign cmd_any = cmd_inval || cmd_clean;
   assign adv     = (st == ST_SCAN && !scan_wb) || (st == ST_FLWB && mem_ack);

   assign cpu_ready = (st == ST_RESP);
   assign cpu_rdata = rdata_q;
   assign cmd_done  = (st == ST_FDONE);

   always_comb begin
      mem_req     = 1'b0;
      mem_we      = 1'b0;
      mem_addr    = addr_q[ADDR_W-1:OFF_W];
      mem_be      = '1;
      mem_wdata   = {BYTES{wdata_q}};
      ts_wr_en    = 1'b0;
      ts_wr_way   = way_q;
      ts_wr_tag   = cur_tag;
      ts_wr_dirty = 1'b0;
      ts_lru_en   = 1'b0;
      ts_lru_val  = 1'b0;
      ts_clr_en   = 1'b0;
      ts_clr_way  = fl_way;
      ds_wr_en    = 1'b0;
      ds_wr_way   = way_q;
      ds_wr_line  = mem_rdata;
      unique case (st)
         ST_IDLE: begin
            if (!cmd_any && cpu_req && !cfg_disable && hit) begin
               ts_lru_en  = 1'b1;
               ts_lru_val = !hit_way;
               if (cpu_we) begin
                  ds_wr_en   = 1'b1;
                  ds_wr_way  = hit_way;
                  ds_wr_line = merge_byte(ds_line[hit_way], cur_off, cpu_wdata);
                  if (!cfg_wthru) begin
                     ts_wr_en    = 1'b1;
                     ts_wr_way   = hit_way;
                     ts_wr_dirty = 1'b1;
                  end
               end
            end
         end
         ST_MEM: begin
            mem_req = 1'b1;
            mem_we  = we_q;
            if (we_q) mem_be = BYTES'(1) << cur_off;
         end
         ST_EVICT: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = {ts_tag[way_q], cur_set};
            mem_wdata = ds_line[way_q];
         end
         ST_FILL: begin
            mem_req = 1'b1;
            if (mem_ack) begin
               ds_wr_en    = 1'b1;
               ds_wr_line  = we_q ? merge_byte(mem_rdata, cur_off, wdata_q) : mem_rdata;
               ts_wr_en    = 1'b1;
               ts_wr_dirty = we_q;
               ts_lru_en   = 1'b1;
               ts_lru_val  = !way_q;
            end
         end
         ST_SCAN: ts_clr_en = !scan_wb;
         ST_FLWB: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = {ts_tag[fl_way], fl_set};
            mem_wdata = ds_line[fl_way];
            ts_clr_en = mem_ack;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         addr_q   <= '0;
         we_q     <= 1'b0;
         wdata_q  <= '0;
         rdata_q  <= '0;
         way_q    <= 1'b0;
         fl_set   <= '0;
         fl_way   <= 1'b0;
         fl_clean <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (cmd_any) begin
                  fl_clean <= cmd_clean;
                  fl_set   <= '0;
                  fl_way   <= 1'b0;
                  st       <= ST_SCAN;
               end else if (cpu_req) begin
                  addr_q  <= cpu_addr;
                  we_q    <= cpu_we;
                  wdata_q <= cpu_wdata;
                  if (cfg_disable) begin
                     st <= ST_MEM;
                  end else if (hit) begin
                     rdata_q <= pick_byte(ds_line[hit_way], cur_off);
                     st      <= (cpu_we && cfg_wthru) ? ST_MEM : ST_RESP;
                  end else if (cpu_we && cfg_wthru) begin
                     st <= ST_MEM;
                  end else begin
                     way_q <= victim;
                     st    <= (ts_valid[victim] && ts_dirty[victim]) ? ST_EVICT : ST_FILL;
                  end
               end
            end
            ST_MEM, ST_FILL: begin
               if (mem_ack) begin
                  rdata_q <= pick_byte(mem_rdata, cur_off);
                  st      <= ST_RESP;
               end
            end
            ST_EVICT: if (mem_ack) st <= ST_FILL;
            ST_SCAN:  if (scan_wb) st <= ST_FLWB;
            default:  if (st == ST_RESP || st == ST_FDONE) st <= ST_IDLE;
         endcase
         if (adv) begin
            if (fl_last) begin
               st <= ST_FDONE;
            end else begin
               fl_way <= !fl_way;
               if (fl_way) fl_set <= fl_set + 1'b1;
               if (st == ST_FLWB) st <= ST_SCAN;
            end
         end
      end
   end

   // R11
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

   // R11
   ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ready || cmd_done) |=> !(cpu_ready || cmd_done));

   // R6
   evict_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FILL && $past(st) == ST_EVICT) |-> $past(mem_ack));

   // R10
   inval_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_SCAN || st == ST_FLWB) && !fl_clean) |-> !mem_req);
endmodule

// File: rtl/cache_wb2way.sv
module cache_wb2way #(
   parameter int ADDR_W = 24,
   parameter int SET_W  = 6,
   parameter int OFF_W  = 2,
   localparam int TAG_W   = ADDR_W - SET_W - OFF_W,
   localparam int BYTES   = 1 << OFF_W,
   localparam int LINE_W  = 8 * BYTES,
   localparam int LADDR_W = ADDR_W - OFF_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_disable,
   input  logic               cfg_wthru,
   input  logic               cmd_inval,
   input  logic               cmd_clean,
   output logic               cmd_done,
   input  logic               cpu_req,
   input  logic               cpu_we,
   input  logic [ADDR_W-1:0]  cpu_addr,
   input  logic [7:0]         cpu_wdata,
   output logic               cpu_ready,
   output logic [7:0]         cpu_rdata,
   output logic               mem_req,
   output logic               mem_we,
   output logic [LADDR_W-1:0] mem_addr,
   output logic [BYTES-1:0]   mem_be,
   output logic [LINE_W-1:0]  mem_wdata,
   input  logic               mem_ack,
   input  logic [LINE_W-1:0]  mem_rdata
);
   if (SET_W < 1 || OFF_W < 1 || TAG_W < 1) begin : g_bad_cfg
      $error("cache_wb2way: ADDR_W must exceed SET_W + OFF_W, both at least 1");
   end

   logic [SET_W-1:0]       ts_set;
   logic [1:0]             ts_valid, ts_dirty;
   logic [1:0][TAG_W-1:0]  ts_tag;
   logic                   ts_lru;
   logic                   ts_wr_en, ts_wr_way, ts_wr_dirty;
   logic [TAG_W-1:0]       ts_wr_tag;
   logic                   ts_lru_en, ts_lru_val, ts_clr_en, ts_clr_way;
   logic [1:0][LINE_W-1:0] ds_line;
   logic                   ds_wr_en, ds_wr_way;
   logic [LINE_W-1:0]      ds_wr_line;

   cache_ctrl #(.ADDR_W(ADDR_W), .SET_W(SET_W), .OFF_W(OFF_W)) ctrl_i (
      .clk, .rst_n, .cfg_disable, .cfg_wthru, .cmd_inval, .cmd_clean, .cmd_done,
      .cpu_req, .cpu_we, .cpu_addr, .cpu_wdata, .cpu_ready, .cpu_rdata,
      .mem_req, .mem_we, .mem_addr, .mem_be, .mem_wdata, .mem_ack, .mem_rdata,
      .ts_set, .ts_valid, .ts_dirty, .ts_tag, .ts_lru,
      .ts_wr_en, .ts_wr_way, .ts_wr_tag, .ts_wr_dirty,
      .ts_lru_en, .ts_lru_val, .ts_clr_en, .ts_clr_way,
      .ds_line, .ds_wr_en, .ds_wr_way, .ds_wr_line
   );

   cache_tag_store #(.SET_W(SET_W), .TAG_W(TAG_W)) tags_i (
      .clk, .rst_n, .cfg_disable, .cfg_wthru,
      .rd_set(ts_set), .rd_valid(ts_valid), .rd_dirty(ts_dirty), .rd_tag(ts_tag), .rd_lru(ts_lru),
      .wr_en(ts_wr_en), .wr_way(ts_wr_way), .wr_tag(ts_wr_tag), .wr_dirty(ts_wr_dirty),
      .lru_en(ts_lru_en), .lru_val(ts_lru_val), .clr_en(ts_clr_en), .clr_way(ts_clr_way)
   );

   cache_data_store #(.SET_W(SET_W), .LINE_W(LINE_W)) data_i (
      .clk, .rd_set(ts_set), .rd_line(ds_line),
      .wr_en(ds_wr_en), .wr_way(ds_wr_way), .wr_line(ds_wr_line)
   );
endmodule

// File: tb/cache_wb2way_tb.sv
module cache_wb2way_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 10;
   localparam int SW = 2;
   localparam int OW = 2;
   localparam int NBYTES = 1 << AW;
   localparam int NLINES = 1 << (AW - OW);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_disable = 1'b0, cfg_wthru = 1'b0;
   logic cmd_inval = 1'b0, cmd_clean = 1'b0, cmd_done;
   logic cpu_req = 1'b0, cpu_we = 1'b0, cpu_ready;
   logic [AW-1:0] cpu_addr = '0;
   logic [7:0] cpu_wdata = '0, cpu_rdata;
   logic mem_req, mem_we;
   logic mem_ack = 1'b0;
   logic [AW-OW-1:0] mem_addr;
   logic [3:0] mem_be;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;

   logic [31:0] mem [NLINES];
   logic [7:0]  ref_b [NBYTES];
   int rd_cnt = 0, wr_cnt = 0;
   logic [3:0] last_be = '0;
   int checks = 0, errors = 0;
   logic [7:0] q;

   always #(CLK_PERIOD / 2) clk = ~clk;

   cache_wb2way #(.ADDR_W(AW), .SET_W(SW), .OFF_W(OW)) dut_i (
      .clk, .rst_n, .cfg_disable, .cfg_wthru, .cmd_inval, .cmd_clean, .cmd_done,
      .cpu_req, .cpu_we, .cpu_addr, .cpu_wdata, .cpu_ready, .cpu_rdata,
      .mem_req, .mem_we, .mem_addr, .mem_be, .mem_wdata, .mem_ack, .mem_rdata
   );

   always @(negedge clk) begin
      if (mem_ack) begin
         mem_ack = 1'b0;
      end else if (mem_req) begin
         mem_ack   = 1'b1;
         mem_rdata = mem[mem_addr];
         if (mem_we) begin
            for (int b = 0; b < 4; b++)
               if (mem_be[b]) mem[mem_addr][8*b +: 8] = mem_wdata[8*b +: 8];
            last_be = mem_be;
            wr_cnt++;
         end else begin
            rd_cnt++;
         end
      end
   end

   function automatic int ad(int tg, int st, int of);
      return tg * 16 + st * 4 + of;
   endfunction

   function automatic logic [7:0] init_b(int a);
      return 8'((a * 7 + 3) & 255);
   endfunction

   function automatic logic [7:0] mb(int a);
      return mem[a / 4][8 * (a % 4) +: 8];
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic access(input logic we, input int a, input logic [7:0] d, output logic [7:0] r);
      @(negedge clk);
      rd_cnt = 0;
      wr_cnt = 0;
      cpu_req = 1'b1;
      cpu_we = we;
      cpu_addr = AW'(a);
      cpu_wdata = d;
      do @(negedge clk); while (!cpu_ready);
      r = cpu_rdata;
      cpu_req = 1'b0;
      if (we && !cfg_disable) ref_b[a] = d;
   endtask

   task automatic command(input bit clean);
      @(negedge clk);
      rd_cnt = 0;
      wr_cnt = 0;
      cmd_clean = clean;
      cmd_inval = !clean;
      do @(negedge clk); while (!cmd_done);
      cmd_clean = 1'b0;
      cmd_inval = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < NLINES; i++)
         for (int b = 0; b < 4; b++) mem[i][8*b +: 8] = init_b(i * 4 + b);
      for (int a = 0; a < NBYTES; a++) ref_b[a] = init_b(a);
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!cpu_ready && !cmd_done && !mem_req, "R1", {cpu_ready, cmd_done, mem_req}, 0);
      rst_n = 1'b1;

      // R1 R2 R3 R4 sweep over every set with three competing tags
      for (int s = 0; s < 4; s++) begin
         access(0, ad(0, s, s), 0, q);
         chk(q == ref_b[ad(0, s, s)], "R3", q, ref_b[ad(0, s, s)]);
         chk(rd_cnt == 1 && wr_cnt == 0, "R1", rd_cnt, 1);
         access(0, ad(1, s, 3 - s), 0, q);
         chk(q == ref_b[ad(1, s, 3 - s)] && rd_cnt == 1, "R3", rd_cnt, 1);
         access(0, ad(2, s, 1), 0, q);
         chk(rd_cnt == 1 && wr_cnt == 0, "R4", wr_cnt, 0);
         access(0, ad(2, s, 2), 0, q);
         chk(q == ref_b[ad(2, s, 2)] && rd_cnt == 0, "R2", rd_cnt, 0);
         access(0, ad(1, s, 0), 0, q);
         chk(rd_cnt == 0, "R4", rd_cnt, 0);
         access(0, ad(0, s, 2), 0, q);
         chk(q == ref_b[ad(0, s, 2)] && rd_cnt == 1, "R4", rd_cnt, 1);
         for (int o = 0; o < 4; o++) begin
            access(0, ad(1, s, o), 0, q);
            chk(q == ref_b[ad(1, s, o)] && rd_cnt == 0, "R2", q, ref_b[ad(1, s, o)]);
         end
      end
      @(negedge clk);
      // R11 ready is a single-cycle pulse
      chk(!cpu_ready, "R11", cpu_ready, 0);

      command(0);
      // R10 invalidate makes no transfer
      chk(wr_cnt == 0 && rd_cnt == 0, "R10", wr_cnt, 0);

      // R5 write-back allocation and hits
      access(1, ad(5, 1, 2), 8'hA5, q);
      chk(rd_cnt == 1 && wr_cnt == 0, "R5", wr_cnt, 0);
      chk(mb(ad(5, 1, 2)) == init_b(ad(5, 1, 2)), "R5", mb(ad(5, 1, 2)), init_b(ad(5, 1, 2)));
      access(1, ad(5, 1, 0), 8'h3C, q);
      chk(rd_cnt == 0 && wr_cnt == 0, "R5", wr_cnt, 0);
      access(0, ad(5, 1, 2), 0, q);
      chk(q == 8'hA5 && rd_cnt == 0, "R5", q, 8'hA5);

      // R6 dirty victim before fill, clean victim silent
      access(0, ad(6, 1, 0), 0, q);
      chk(rd_cnt == 1 && wr_cnt == 0, "R4", rd_cnt, 1);
      access(0, ad(7, 1, 1), 0, q);
      chk(wr_cnt == 1 && rd_cnt == 1, "R6", wr_cnt, 1);
      chk(mb(ad(5, 1, 2)) == 8'hA5 && mb(ad(5, 1, 0)) == 8'h3C, "R6", mb(ad(5, 1, 0)), 8'h3C);
      chk(q == ref_b[ad(7, 1, 1)], "R6", q, ref_b[ad(7, 1, 1)]);
      access(0, ad(8, 1, 3), 0, q);
      chk(wr_cnt == 0 && rd_cnt == 1, "R6", wr_cnt, 0);

      // R9 clean command
      for (int s = 0; s < 4; s++) access(1, ad(9, s, s), 8'(8'h50 + s), q);
      chk(mb(ad(9, 2, 2)) == init_b(ad(9, 2, 2)), "R5", mb(ad(9, 2, 2)), init_b(ad(9, 2, 2)));
      command(1);
      chk(wr_cnt == 4, "R9", wr_cnt, 4);
      begin
         int bad = 0;
         for (int a = 0; a < NBYTES; a++) if (mb(a) != ref_b[a]) bad++;
         chk(bad == 0, "R9", bad, 0);
      end
      access(0, ad(9, 0, 0), 0, q);
      chk(rd_cnt == 1 && q == ref_b[ad(9, 0, 0)], "R9", rd_cnt, 1);

      // R10 plain invalidate discards dirty data
      access(1, ad(10, 2, 1), 8'hEE, q);
      command(0);
      chk(wr_cnt == 0, "R10", wr_cnt, 0);
      ref_b[ad(10, 2, 1)] = init_b(ad(10, 2, 1));
      access(0, ad(10, 2, 1), 0, q);
      chk(q == init_b(ad(10, 2, 1)) && rd_cnt == 1, "R10", q, init_b(ad(10, 2, 1)));

      // R7 write-through
      cfg_wthru = 1'b1;
      access(0, ad(11, 3, 0), 0, q);
      access(1, ad(11, 3, 3), 8'h77, q);
      chk(wr_cnt == 1 && rd_cnt == 0 && mb(ad(11, 3, 3)) == 8'h77, "R7", wr_cnt, 1);
      chk(last_be == 4'b1000, "R7", last_be, 8);
      access(0, ad(11, 3, 3), 0, q);
      chk(q == 8'h77 && rd_cnt == 0, "R7", q, 8'h77);
      access(1, ad(12, 3, 1), 8'h12, q);
      chk(wr_cnt == 1 && rd_cnt == 0 && last_be == 4'b0010, "R7", last_be, 2);
      access(0, ad(12, 3, 1), 0, q);
      chk(rd_cnt == 1 && q == 8'h12, "R7", rd_cnt, 1);
      command(1);
      chk(wr_cnt == 0, "R7", wr_cnt, 0);
      cfg_wthru = 1'b0;

      // R8 cache disabled
      cfg_disable = 1'b1;
      for (int k = 0; k < 2; k++) begin
         access(0, ad(12, 3, 1), 0, q);
         chk(rd_cnt == 1 && q == 8'h12, "R8", rd_cnt, 1);
      end
      access(1, ad(13, 0, 2), 8'h99, q);
      ref_b[ad(13, 0, 2)] = 8'h99;
      chk(wr_cnt == 1 && last_be == 4'b0100 && mb(ad(13, 0, 2)) == 8'h99, "R8", mb(ad(13, 0, 2)), 8'h99);
      chk(mb(ad(13, 0, 1)) == ref_b[ad(13, 0, 1)], "R8", mb(ad(13, 0, 1)), ref_b[ad(13, 0, 1)]);
      cfg_disable = 1'b0;
      access(0, ad(12, 3, 1), 0, q);
      chk(rd_cnt == 1, "R8", rd_cnt, 1);
      access(0, ad(13, 0, 2), 0, q);
      chk(rd_cnt == 1 && q == 8'h99, "R8", q, 8'h99);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule